// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Byte-Lane Writes

This block is a behavioural model of a clocked static RAM with its own storage array. It is meant to stand as the memory target in a larger test environment. Chip select, write enable, the per-lane write enables, the burst-advance input, the burst-order input and the address are all captured on the rising clock edge. Data moves over one shared bidirectional bus. Read data goes through a single register and is driven in the clock period that follows the accepted read.

A cycle with the advance input low loads a fresh address and starts a burst at beat zero. A cycle with advance high reuses the loaded address and steps a 2-bit beat counter. The counter supplies the two low address bits, either XOR-combined with the loaded start bits or added to them modulo four. The bus is released whenever the sleep input is high, whenever output enable is high, and in every cycle that does not follow an accepted read. Writes take their data from the bus at the same edge that captures the address, so the bus master must already have freed the bus with output enable.

Top module: `sync_burst_sram`

## Requirements
- R1: With chip select low (cs_n=0) and write enable high (we_n=1) at a rising edge, the word at the access address is driven on dq from just after that edge until the next edge, provided oe_n=0 and sleep=0. The byte-lane enables bw_n have no effect on a read.
- R2: With cs_n=0 and we_n=0 at an edge, each lane i whose bw_n[i]=0 takes dq bits [9i+8:9i] into the addressed word. Lane 0 holds the lowest bits. Lanes whose bw_n bit is 1 keep their old contents.
- R3: A write cycle with every bw_n bit equal to 1 leaves the memory unchanged. In the period after any write cycle, dq is not driven.
- R4: With mode=1, beat b of a burst accesses the loaded address with its two low bits replaced by (start low bits XOR b).
- R5: With mode=0, beat b of a burst accesses the loaded address with its two low bits replaced by (start low bits + b) modulo 4. The upper address bits never change during a burst.
- R6: A selected cycle with adv=0 loads addr and uses beat 0. A selected cycle with adv=1 uses the previous beat plus one, modulo 4, so the fifth beat wraps back to the start address.
- R7: While sleep=1, dq is high impedance whatever the other inputs are. Once sleep returns to 0, a pending read drives again within the same period.
- R8: During the period after a read, dq is high impedance while oe_n=1.
- R9: A cycle with cs_n=1 writes nothing, leaves dq undriven in the following period, and keeps the loaded address and beat count for the next advance.
- R10: After reset, dq is high impedance until a read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Active-low reset of control state (array not cleared) |
| cs_n | input | 1 | Active-low chip select |
| adv | input | 1 | 1: advance burst beat, 0: load new address |
| mode | input | 1 | Burst order: 1 XOR order, 0 modulo-4 add order |
| we_n | input | 1 | Active-low write enable |
| bw_n | input | LANES | Active-low per-lane write enables, bit 0 = lowest lane |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Asynchronous bus release, overrides everything |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
A read's data is due in the period after the edge that accepts it, so the bench samples dq at the falling edge that follows each access edge. Write data, the burst beat and deselection all take effect at that same accepting edge, and each is checked through the next read's value half a period after it is accepted. Output enable and sleep act on dq without a register, so their effect is checked a few nanoseconds after the level changes, inside the same period. A pull-up on every bus bit makes high impedance read as all ones, and no checked data word is all ones.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int unsigned BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    // low address bits for a given beat of a burst
    function automatic beat_t burst_low(input beat_t start, input beat_t beat,
                                        input logic xor_order);
        beat_t r;
        if (xor_order) r = start ^ beat;
        else           r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] base_q,
    output beat_t             beat_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        beat_t             beat;
    } agen_st_t;

    agen_st_t st_d, st_q;
    logic [ADDR_W-1:0] base_now;
    beat_t             beat_now;

    always_comb begin
        st_d     = st_q;
        base_now = adv ? st_q.base : addr;
        beat_now = adv ? beat_t'(st_q.beat + beat_t'(1)) : '0;
        acc_addr = {base_now[ADDR_W-1:BEAT_W],
                    burst_low(base_now[BEAT_W-1:0], beat_now, mode)};
        if (!cs_n) begin
            st_d.base = base_now;
            st_d.beat = beat_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q = st_q.base;
    assign beat_q = st_q.beat;

endmodule

// File: rtl/lane_array.sv
module lane_array #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DEPTH  = 1 << ADDR_W,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_d, rd_q;
        logic              we_lane;

        always_comb begin
            we_lane = wr_en & ~bw_n[g];
            rd_d    = rd_en ? mem[addr] : rd_q;
        end

        always_ff @(posedge clk) begin
            if (we_lane) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_d;
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/bus_ctrl.sv
module bus_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start,
    input  logic oe_n,
    input  logic sleep,
    output logic rd_q,
    output logic drive_en
);

    logic rd_d;

    always_comb begin
        rd_d     = rd_start;
        drive_en = rd_q & ~oe_n & ~sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_d;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv,
    input  logic              mode,
    input  logic              we_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe_n,
    input  logic              sleep,
    inout  wire  [DATA_W-1:0] dq
);

    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] base_q;
    beat_t             beat_q;
    logic [DATA_W-1:0] rdata;
    logic              rd_start, wr_en, rd_q, drive_en;

    assign rd_start = ~cs_n & we_n;
    assign wr_en    = ~cs_n & ~we_n;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .adv      (adv),
        .mode     (mode),
        .addr     (addr),
        .acc_addr (acc_addr),
        .base_q   (base_q),
        .beat_q   (beat_q)
    );

    lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_start),
        .bw_n  (bw_n),
        .addr  (acc_addr),
        .wdata (dq),
        .rdata (rdata)
    );

    bus_ctrl u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .rd_q     (rd_q),
        .drive_en (drive_en)
    );

    assign dq = drive_en ? rdata : {DATA_W{1'bz}};

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic              adv,
    input logic              rd_q,
    input logic [ADDR_W-1:0] base_q,
    input logic [1:0]        beat_q
);

    a_r1_read_arms_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && we_n) |=> rd_q);

    a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !we_n) |=> !rd_q);

    a_r9_deselect_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !rd_q);

    a_r6_load_beat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !adv) |=> (beat_q == 2'd0));

    a_r6_advance_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && adv) |=> (beat_q == 2'($past(beat_q) + 2'd1)));

    a_r9_deselect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(beat_q) && $stable(base_q)));

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .we_n   (we_n),
    .adv    (adv),
    .rd_q   (rd_q),
    .base_q (base_q),
    .beat_q (beat_q)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;

    localparam int AW = 6;
    localparam int DW = 36;
    localparam logic [DW-1:0] HIZ = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, adv = 1'b0, mode = 1'b1, we_n = 1'b1, oe_n = 1'b0, sleep = 1'b0;
    logic [3:0]    bw_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] tb_dq = '0;
    logic          tb_en = 1'b0;
    wire  [DW-1:0] dq;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign dq = tb_en ? tb_dq : {DW{1'bz}};
    for (genvar i = 0; i < DW; i++) begin : g_pu
        pullup pu (dq[i]);
    end

    sync_burst_sram dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv(adv), .mode(mode),
        .we_n(we_n), .bw_n(bw_n), .addr(addr), .oe_n(oe_n), .sleep(sleep), .dq(dq)
    );

    typedef struct packed {
        logic          cs_n, we_n, adv, mode;
        logic [3:0]    bw_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic          oe_n;
        logic [3:0]    req;
        logic [DW-1:0] exp;
    } vec_t;

    localparam logic [DW-1:0] W0 = {9'h044, 9'h033, 9'h022, 9'h011};
    localparam logic [DW-1:0] WP = {9'h1DD, 9'h1CC, 9'h1BB, 9'h1AA};
    localparam logic [DW-1:0] W1 = {9'h044, 9'h1CC, 9'h022, 9'h1AA};

    localparam vec_t VECS [11] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 6'h04, W0,  1'b1, 4'd3,  HIZ}, // R3 write, no drive
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b0, 4'd1,  W0},  // R1 read
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'b1010, 6'h04, WP,  1'b1, 4'd3,  HIZ}, // R2 lanes 0,2
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b0, 4'd2,  W1},  // R2 merged word
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b1, 4'd3,  HIZ}, // R3 abort
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b0, 4'd3,  W1},  // R3 unchanged
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b1, 4'd8,  HIZ}, // R8 oe_n high
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b0000, 6'h04, '0,  1'b0, 4'd1,  W1},  // R1 bw_n ignored
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b0, 4'd1,  W1},  // R1 still same
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'b0000, 6'h04, '0,  1'b0, 4'd9,  HIZ}, // R9 deselected
        '{1'b0, 1'b1, 1'b0, 1'b1, 4'b1111, 6'h04, '0,  1'b0, 4'd9,  W1}   // R9 no write
    };

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {4{3'b101, a}};
    endfunction

    function automatic logic [AW-1:0] baddr(input logic [AW-1:0] s, input logic [1:0] b,
                                            input logic m);
        logic [1:0] lo;
        lo = m ? (s[1:0] ^ b) : 2'(s[1:0] + b);
        return {s[AW-1:2], lo};
    endfunction

    task automatic check(input int req, input logic [DW-1:0] exp);
        checks++;
        if (dq !== exp) begin
            errors++;
            $display("FAIL R%0d: dq=%h expected %h", req, dq, exp);
        end
    endtask

    task automatic step(input logic c, input logic w, input logic a_v, input logic m,
                        input logic [3:0] bw, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic oe);
        cs_n = c; we_n = w; adv = a_v; mode = m; bw_n = bw; addr = a; oe_n = oe;
        tb_dq = wd; tb_en = !c && !w;
        @(posedge clk);
        #1 tb_en = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(10, HIZ);

        // table walk
        foreach (VECS[k]) begin
            step(VECS[k].cs_n, VECS[k].we_n, VECS[k].adv, VECS[k].mode,
                 VECS[k].bw_n, VECS[k].addr, VECS[k].wd, VECS[k].oe_n);
            check(int'(VECS[k].req), VECS[k].exp);
        end

        // fill a burst block
        for (int a = 16; a < 20; a++)
            step(1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, AW'(a), pat(AW'(a)), 1'b1);

        // R4 XOR order from start 01, then R6 wrap
        step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h11, '0, 1'b0);
        check(6, pat(6'h11));
        for (int b = 1; b < 4; b++) begin
            step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, '0, 1'b0);
            check(4, pat(baddr(6'h11, 2'(b), 1'b1)));
        end
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, '0, 1'b0);
        check(6, pat(6'h11));

        // R5 add order from start 11
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'hF, 6'h13, '0, 1'b0);
        check(5, pat(6'h13));
        for (int b = 1; b < 4; b++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 6'h3C, '0, 1'b0);
            check(5, pat(baddr(6'h13, 2'(b), 1'b0)));
        end

        // R9 deselect keeps burst position
        step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h12, '0, 1'b0);
        check(9, pat(6'h12));
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, '0, 1'b0);
        check(9, HIZ);
        step(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, '0, 1'b0);
        check(9, pat(6'h13));

        // R7 sleep overrides a pending read
        sleep = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h10, '0, 1'b0);
        check(7, HIZ);
        #2 sleep = 1'b0;
        #2 check(7, pat(6'h10));

        // R8 output enable acts within the period
        #2 oe_n = 1'b1;
        #2 check(8, HIZ);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule